// File: doc/BRIEF.md
# Dual Shared GPIO Port With Masked Change Notification

This block holds two 16-pin general-purpose ports, A and B, behind one small register bus. Each port owns a 32-bit control word and a 16-bit data word. In the control word the output-enable and the pull-up enable of each pin sit side by side. On-chip peripherals share the pins through a second set of inputs: a drive value and a drive enable per pin. For every pin the block resolves one logical level from the CPU drive, the peripheral drive and the pull-up. A pin that nobody drives and that has no pull-up reads low.

Whenever the bus writes a control or data word, the block compares the resolved levels of that port just before and just after the write. Their XOR is the changed-pin vector. Four listener ports each carry one trigger mask for port A and one for port B. A listener receives a one-cycle, registered notification strobe in the cycle after the write if its mask for the written port overlaps the changed-pin vector. The resolved levels of both ports are always present on outputs, so a notified peripheral can react by updating its own drive inputs. Changes caused only by the peripheral inputs never raise a notification.

Top module: `shared_gpio_port`

## Requirements
- R1: While reset is applied and after its release, both control words and both data words are zero, all resolved levels are zero and no notification strobe is high.
- R2: In a port's control word, bit 2n is the CPU output-enable of pin n and bit 2n+1 is the pull-up enable of pin n (n = 0..15).
- R3: The level of pin n is (cpu_oe AND cpu_data) OR (per_oe AND per_drv) OR (NOT(cpu_oe OR per_oe) AND pull-up), so CPU and peripheral drives combine as a wired OR.
- R4: Bus addresses are 0 = control A, 1 = data A, 2 = control B, 3 = data B. A read of a data address returns the resolved levels in bits 15:0 with zeros above, not the stored CPU data.
- R5: A write that leaves the resolved levels of the written port unchanged raises no notification strobe.
- R6: A notification strobe is high for exactly the one cycle after the write that caused it.
- R7: Listener i (strobe bit i) is notified only if its mask for the written port ANDed with the changed-pin vector is nonzero. Listeners whose masks do not overlap stay low.
- R8: A write to one port leaves the other port's levels unchanged. It is judged only against the listener masks for the written port.
- R9: A read of a control address returns the full 32-bit word last written.
- R10: A change of level caused only by the peripheral inputs, with no bus write, raises no notification strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| per_drv_a | input | 16 | Peripheral drive values, port A |
| per_oe_a | input | 16 | Peripheral drive enables, port A |
| per_drv_b | input | 16 | Peripheral drive values, port B |
| per_oe_b | input | 16 | Peripheral drive enables, port B |
| lsn_mask_a | input | 64 | Trigger masks for port A, 16 bits per listener, listener i in bits 16i+15:16i |
| lsn_mask_b | input | 64 | Trigger masks for port B, same layout |
| lvl_a | output | 16 | Resolved levels, port A |
| lvl_b | output | 16 | Resolved levels, port B |
| lsn_notify | output | 4 | One-cycle notification strobe per listener |

## Verification
The bench writes data to a pin whose output-enable is off. A design that returned stored data instead of resolved levels would show the written bits, and one that notified on any write would pulse with no level change. It turns pull-ups on and off and lets a peripheral drive a pin that also has a pull-up. An exchanged even/odd mapping or a wrong resolution term would give the wrong level there. It changes peripheral inputs without a write, where a design comparing levels every cycle would notify. It writes port B with masks that exclude port A. A design that mixed the two ports' masks or changed vectors would strobe the wrong listeners or disturb port A's levels.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PINS_DEF = 16;
  localparam int LSN_DEF  = 4;

  // Register select on the low address bit, port on the high bit
  typedef enum logic [1:0] {
    SEL_CTRL_A = 2'd0,
    SEL_DATA_A = 2'd1,
    SEL_CTRL_B = 2'd2,
    SEL_DATA_B = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int PINS = 16,
  localparam int CW  = 2 * PINS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl,
  input  logic            wr_data,
  input  logic [CW-1:0]   wdata,
  input  logic [PINS-1:0] per_drv,
  input  logic [PINS-1:0] per_oe,
  output logic [CW-1:0]   ctrl_q,
  output logic [PINS-1:0] level,
  output logic [PINS-1:0] chg
);
  logic [PINS-1:0] data_q;
  logic [CW-1:0]   ctrl_d;
  logic [PINS-1:0] data_d;
  logic [PINS-1:0] oe_cur, pu_cur, oe_nxt, pu_nxt;
  logic [PINS-1:0] lvl_nxt;

  function automatic logic [PINS-1:0] resolve(
    input logic [PINS-1:0] c_oe, input logic [PINS-1:0] c_dat,
    input logic [PINS-1:0] p_oe, input logic [PINS-1:0] p_dat,
    input logic [PINS-1:0] pull);
    return (c_oe & c_dat) | (p_oe & p_dat) | (~(c_oe | p_oe) & pull);
  endfunction

  // Next-state
  always_comb begin
    ctrl_d = ctrl_q;
    data_d = data_q;
    if (wr_ctrl) ctrl_d = wdata;
    if (wr_data) data_d = wdata[PINS-1:0];
  end

  // Registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (wr_data) begin
      data_q <= data_d;
    end
  end

  // Interleaved control word: even bit enables the drive, odd bit the pull-up
  for (genvar n = 0; n < PINS; n++) begin : g_unzip
    assign oe_cur[n] = ctrl_q[2*n];
    assign pu_cur[n] = ctrl_q[2*n+1];
    assign oe_nxt[n] = ctrl_d[2*n];
    assign pu_nxt[n] = ctrl_d[2*n+1];
  end

  assign level   = resolve(oe_cur, data_q, per_oe, per_drv, pu_cur);
  assign lvl_nxt = resolve(oe_nxt, data_d, per_oe, per_drv, pu_nxt);
  // Zero whenever no write is present, as both views then agree
  assign chg     = level ^ lvl_nxt;
endmodule

// File: rtl/gpio_notify.sv
module gpio_notify #(
  parameter int PINS = 16,
  parameter int LSN  = 4,
  localparam int MW  = PINS * LSN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] chg_a,
  input  logic [PINS-1:0] chg_b,
  input  logic [MW-1:0]   mask_a,
  input  logic [MW-1:0]   mask_b,
  output logic [LSN-1:0]  notify
);
  logic [LSN-1:0] notify_d;

  for (genvar i = 0; i < LSN; i++) begin : g_lsn
    assign notify_d[i] = (|(mask_a[i*PINS +: PINS] & chg_a)) |
                         (|(mask_b[i*PINS +: PINS] & chg_b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) notify <= '0;
    else        notify <= notify_d;
  end
endmodule

// File: rtl/shared_gpio_port.sv
module shared_gpio_port #(
  parameter int PINS = gpio_pkg::PINS_DEF,
  parameter int LSN  = gpio_pkg::LSN_DEF,
  localparam int CW  = 2 * PINS,
  localparam int MW  = PINS * LSN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [CW-1:0]   bus_wdata,
  output logic [CW-1:0]   bus_rdata,
  input  logic [PINS-1:0] per_drv_a,
  input  logic [PINS-1:0] per_oe_a,
  input  logic [PINS-1:0] per_drv_b,
  input  logic [PINS-1:0] per_oe_b,
  input  logic [MW-1:0]   lsn_mask_a,
  input  logic [MW-1:0]   lsn_mask_b,
  output logic [PINS-1:0] lvl_a,
  output logic [PINS-1:0] lvl_b,
  output logic [LSN-1:0]  lsn_notify
);
  import gpio_pkg::*;

  logic            rst_n_sync;
  logic [1:0]      wr_ctrl_v, wr_data_v;
  logic [PINS-1:0] per_drv_v [2];
  logic [PINS-1:0] per_oe_v  [2];
  logic [CW-1:0]   ctrl_v    [2];
  logic [PINS-1:0] lvl_v     [2];
  logic [PINS-1:0] chg_v     [2];

  gpio_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  assign per_drv_v[0] = per_drv_a;
  assign per_drv_v[1] = per_drv_b;
  assign per_oe_v[0]  = per_oe_a;
  assign per_oe_v[1]  = per_oe_b;

  // Address decode: bit 1 picks the port, bit 0 picks control or data
  for (genvar p = 0; p < 2; p++) begin : g_port
    assign wr_ctrl_v[p] = bus_wr && (bus_addr[1] == p[0]) && !bus_addr[0];
    assign wr_data_v[p] = bus_wr && (bus_addr[1] == p[0]) &&  bus_addr[0];

    gpio_port_bank #(.PINS(PINS)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n_sync),
      .wr_ctrl(wr_ctrl_v[p]),
      .wr_data(wr_data_v[p]),
      .wdata  (bus_wdata),
      .per_drv(per_drv_v[p]),
      .per_oe (per_oe_v[p]),
      .ctrl_q (ctrl_v[p]),
      .level  (lvl_v[p]),
      .chg    (chg_v[p])
    );
  end

  gpio_notify #(.PINS(PINS), .LSN(LSN)) u_notify (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .chg_a (chg_v[0]),
    .chg_b (chg_v[1]),
    .mask_a(lsn_mask_a),
    .mask_b(lsn_mask_b),
    .notify(lsn_notify)
  );

  assign lvl_a = lvl_v[0];
  assign lvl_b = lvl_v[1];

  always_comb begin
    unique case (reg_sel_e'(bus_addr))
      SEL_CTRL_A: bus_rdata = ctrl_v[0];
      SEL_DATA_A: bus_rdata = {{PINS{1'b0}}, lvl_v[0]};
      SEL_CTRL_B: bus_rdata = ctrl_v[1];
      default:    bus_rdata = {{PINS{1'b0}}, lvl_v[1]};
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int PINS = 16,
  parameter int LSN  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [1:0]      bus_addr,
  input logic [2*PINS-1:0] bus_rdata,
  input logic [PINS-1:0] per_drv_a,
  input logic [PINS-1:0] per_oe_a,
  input logic [PINS-1:0] per_drv_b,
  input logic [PINS-1:0] per_oe_b,
  input logic [PINS-1:0] lvl_a,
  input logic [PINS-1:0] lvl_b,
  input logic [LSN-1:0]  lsn_notify
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> lsn_notify == '0);

  // R6
  strobe_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsn_notify != '0 |-> $past(bus_wr));

  // R5
  strobe_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsn_notify != '0 && $stable(per_drv_a) && $stable(per_oe_a) &&
     $stable(per_drv_b) && $stable(per_oe_b))
    |-> (lvl_a != $past(lvl_a) || lvl_b != $past(lvl_b)));

  // R3
  periph_high_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((per_oe_a & per_drv_a & ~lvl_a) == '0) && ((per_oe_b & per_drv_b & ~lvl_b) == '0));

  // R4
  data_read_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[0] |-> bus_rdata == {{PINS{1'b0}}, (bus_addr[1] ? lvl_b : lvl_a)});

  // R8
  other_port_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[1]) |=>
      (!($stable(per_drv_a) && $stable(per_oe_a)) || $stable(lvl_a)));
endmodule

bind shared_gpio_port gpio_port_chk #(.PINS(PINS), .LSN(LSN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .per_drv_a(per_drv_a), .per_oe_a(per_oe_a),
  .per_drv_b(per_drv_b), .per_oe_b(per_oe_b), .lvl_a(lvl_a),
  .lvl_b(lvl_b), .lsn_notify(lsn_notify)
);

// File: tb/test_shared_gpio_port.sv
module test_shared_gpio_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] per_drv_a, per_oe_a, per_drv_b, per_oe_b;
  logic [63:0] lsn_mask_a, lsn_mask_b;
  logic [15:0] lvl_a, lvl_b;
  logic [3:0]  lsn_notify;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  shared_gpio_port i_shared_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .per_drv_a(per_drv_a), .per_oe_a(per_oe_a),
    .per_drv_b(per_drv_b), .per_oe_b(per_oe_b),
    .lsn_mask_a(lsn_mask_a), .lsn_mask_b(lsn_mask_b),
    .lvl_a(lvl_a), .lvl_b(lvl_b), .lsn_notify(lsn_notify)
  );

  typedef struct packed {
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [15:0] pdrv;
    logic [15:0] poe;
    logic [15:0] elvl;
    logic [3:0]  entf;
  } vec_t;

  // Port A writes; listener A masks: l0=0x0001 l1=0x00F0 l2=0xFF00 l3=0
  localparam vec_t VEC [8] = '{
    '{2'd0, 32'h0000_0002, 16'h0000, 16'h0000, 16'h0001, 4'b0001}, // R2 pull pin0
    '{2'd1, 32'h0000_00F0, 16'h0000, 16'h0000, 16'h0001, 4'b0000}, // R5 no oe
    '{2'd0, 32'h0000_5502, 16'h0000, 16'h0000, 16'h00F1, 4'b0010}, // R2 oe pins 4..7
    '{2'd0, 32'h0000_5500, 16'h0000, 16'h0000, 16'h00F0, 4'b0001}, // R7 only l0
    '{2'd1, 32'h0000_0030, 16'h0000, 16'h0000, 16'h0030, 4'b0010}, // R7 only l1
    '{2'd0, 32'h0002_5500, 16'h0100, 16'h0100, 16'h0130, 4'b0000}, // R3 periph pin8
    '{2'd0, 32'h0008_5500, 16'h0100, 16'h0100, 16'h0330, 4'b0100}, // R2 pull pin9
    '{2'd1, 32'h0000_0000, 16'h0100, 16'h0100, 16'h0300, 4'b0010}  // R3 wired OR
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    per_drv_a = '0; per_oe_a = '0; per_drv_b = '0; per_oe_b = '0;
    lsn_mask_a = {16'h0000, 16'hFF00, 16'h00F0, 16'h0001};
    lsn_mask_b = {16'hFFFF, 16'h0000, 16'h0000, 16'h0000};
    repeat (3) @(negedge clk);
    chk("R1 notify in reset", 32'(lsn_notify), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 lvl_a", 32'(lvl_a), 32'h0);
    chk("R1 lvl_b", 32'(lvl_b), 32'h0);
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a);
      #1 chk("R1 register read", bus_rdata, 32'h0);
    end
    chk("R1 notify after reset", 32'(lsn_notify), 32'h0);

    // Vector table
    for (int i = 0; i < 8; i++) begin
      per_drv_a = VEC[i].pdrv;
      per_oe_a  = VEC[i].poe;
      bus_write(VEC[i].addr, VEC[i].wdata);
      chk("R6 R7 notify after write", 32'(lsn_notify), 32'(VEC[i].entf));
      chk("R3 lvl_a", 32'(lvl_a), 32'(VEC[i].elvl));
      bus_addr = 2'd1;
      #1 chk("R4 data read", bus_rdata, 32'(VEC[i].elvl));
      @(negedge clk);
      chk("R6 strobe one cycle", 32'(lsn_notify), 32'h0);
    end

    // Control readback
    bus_addr = 2'd0;
    #1 chk("R9 ctrl A read", bus_rdata, 32'h0008_5500);

    // Peripheral-only change, no write
    @(negedge clk);
    per_drv_a = 16'h0000;
    @(negedge clk);
    chk("R10 lvl_a follows periph", 32'(lvl_a), 32'h0200);
    chk("R10 no notify", 32'(lsn_notify), 32'h0);
    @(negedge clk);
    chk("R10 no notify later", 32'(lsn_notify), 32'h0);

    // Port B
    bus_write(2'd3, 32'h0000_8001);
    chk("R5 B data without oe", 32'(lsn_notify), 32'h0);
    chk("R4 lvl_b undriven", 32'(lvl_b), 32'h0);
    @(negedge clk);
    bus_write(2'd2, 32'h4000_0001);
    chk("R8 B listener only", 32'(lsn_notify), 32'b1000);
    chk("R8 lvl_b", 32'(lvl_b), 32'h8001);
    chk("R8 lvl_a kept", 32'(lvl_a), 32'h0200);
    bus_addr = 2'd2;
    #1 chk("R9 ctrl B read", bus_rdata, 32'h4000_0001);
    bus_addr = 2'd3;
    #1 chk("R4 data B read", bus_rdata, 32'h0000_8001);
    @(negedge clk);
    per_oe_b = 16'h0002; per_drv_b = 16'h0002;
    #1 chk("R3 periph on B", 32'(lvl_b), 32'h8003);

    // Reset again
    @(negedge clk);
    per_oe_a = '0; per_oe_b = '0;
    rst_n = 1'b0;
    #1;
    bus_addr = 2'd0;
    #1 chk("R1 ctrl A cleared", bus_rdata, 32'h0);
    chk("R1 lvl_a cleared", 32'(lvl_a), 32'h0);
    chk("R1 lvl_b cleared", 32'(lvl_b), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule